// File: doc/BRIEF.md
# Cartridge Bank Mapping Register File

This block sits between a game console's CPU bus and a cartridge's program (PRG) and character (CHR) memories. The CPU writes bank numbers into a small set of registers. The block then turns the current CPU and picture-processor (PPU) addresses into the upper address lines of both memories, and into the nametable select line that sets the screen mirroring. Only address bits 3:0 choose a register, so the set repeats every 16 bytes inside the decode window. A parameter sets the decode window to either $6000-$FFFF or $8000-$FFFF.

A small write-strobe state machine commits each CPU write exactly once, however many clocks the strobe is held. It has two states. WR_IDLE waits for a strobe; the transition "strobe seen" commits the write and enters WR_HOLD. WR_HOLD ignores the bus until the transition "strobe released" returns it to WR_IDLE.

The register set holds eight CHR bank numbers, one switchable 16 KiB PRG page and a two-bit mirroring mode. A CHR-RAM build ignores the CHR bank registers and passes the PPU address through. An outer-bank build also passes the PPU address through, and uses bit 0 of the first four CHR registers as PRG address bit 18.

Top module: `bank_mapper_top`

## Requirements
- R1: After a clock with rst_n low, all eight CHR registers and the PRG register read back as 0, and the mirroring mode is 0, so ciram_a10 follows PPU A10.
- R2: Only cpu_addr[3:0] selects a register, so a write anywhere in the window reaches the register at offset cpu_addr[3:0].
- R3: With WIN_FULL=1, writes to $6000-$FFFF are accepted. With WIN_FULL=0, only writes to $8000-$FFFF are accepted. A write outside the window changes no output.
- R4: A strobe held high over several clocks commits one write, using the data present at the first rising clock edge on which the strobe is high. Data changes while the strobe stays high are ignored.
- R5: Offsets 0 to 7 hold 8-bit CHR bank numbers. chr_addr_hi equals the register at offset {PPU A12,A11,A10}, so the 1 KiB regions from $0000 up to $1FFF use registers 0 to 7 in ascending order.
- R6: When cpu_addr[14]=0, prg_addr_hi[3:0] equals bits 3:0 of the last byte written to offset 8. Bits 7:4 of that byte are ignored.
- R7: When cpu_addr[14]=1, prg_addr_hi[3:0] is 4'hF, the last 16 KiB bank.
- R8: Offset 9 bits 1:0 set ciram_a10: 0 gives PPU A10, 1 gives PPU A11, 2 gives 0, 3 gives 1.
- R9: With CHR_RAM=1 or OUTER_MODE=1, chr_addr_hi is {5'b0, PPU A12, A11, A10}, whatever the CHR registers hold.
- R10: With OUTER_MODE=1, prg_addr_hi[4] is bit 0 of the CHR register at offset {A11,A10}, with PPU A12 and A13 treated as 0. Otherwise prg_addr_hi[4] is 0.
- R11: Writes to offsets 10 to 15 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address, used for write decode and PRG half select |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, active high |
| ppu_a13_10 | input | 4 | PPU address bits 13:10, bit 0 is A10 |
| prg_addr_hi | output | 5 | PRG address bits 18:14 |
| chr_addr_hi | output | 8 | CHR address bits 17:10 |
| ciram_a10 | output | 1 | Nametable select for mirroring |

## Verification
Three builds run side by side: the full window with CHR banking, the upper window with CHR RAM, and the upper window with the outer bank. A behavioural model in the bench tracks each build every cycle. The corner cases targeted are these:
- Writes at $6000-$7FFF, which only the full-window build may take. A wrong decode would corrupt banks in the other two builds.
- Mirror aliases such as $F3F4. A decoder that looks at more than four address bits would miss these writes.
- A strobe held over changing data. A level-sensitive commit would latch the last value instead of the first.
- Writes to the unused offsets, the upper nibble of the PRG byte, and PPU A12/A13 in the outer-bank build. Any leak from these would show up as a moving PRG bit 18 or a changed bank.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;

    typedef enum logic [1:0] {
        MIR_VERT = 2'd0,
        MIR_HORZ = 2'd1,
        MIR_LOW  = 2'd2,
        MIR_HIGH = 2'd3
    } mirror_t;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_HOLD = 1'b1
    } wr_state_t;

endpackage

// File: rtl/bank_mapper_wr_fsm.sv
module bank_mapper_wr_fsm
    import bank_mapper_pkg::*;
#(
    parameter bit WIN_FULL = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] addr_hi,
    input  logic       cpu_wr,
    output logic       commit
);

    wr_state_t state;
    wr_state_t state_nx;
    logic      win_hit;

    // Decode window: the upper window needs A15; the full window adds $6000-$7FFF.
    generate
        if (WIN_FULL) begin : g_full_win
            assign win_hit = addr_hi[2] | (addr_hi[1:0] == 2'b11);
        end else begin : g_upper_win
            logic win_unused;
            assign win_unused = ^addr_hi[1:0];
            assign win_hit    = addr_hi[2];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WR_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            WR_IDLE: if (cpu_wr)  state_nx = WR_HOLD;
            WR_HOLD: if (!cpu_wr) state_nx = WR_IDLE;
            default: state_nx = WR_IDLE;
        endcase
    end

    always_comb begin
        commit = 1'b0;
        unique case (state)
            WR_IDLE: commit = cpu_wr & win_hit;
            WR_HOLD: commit = 1'b0;
            default: commit = 1'b0;
        endcase
    end

endmodule

// File: rtl/bank_mapper_regs.sv
module bank_mapper_regs
    import bank_mapper_pkg::*;
#(
    parameter int NUM_CHR    = 8,
    parameter int CHR_BANK_W = 8,
    parameter int PRG_BANK_W = 4,
    parameter int DATA_W     = 8,
    parameter int OFS_W      = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           commit,
    input  logic [OFS_W-1:0]               ofs,
    input  logic [DATA_W-1:0]              data,
    output logic [NUM_CHR*CHR_BANK_W-1:0]  chr_flat,
    output logic [PRG_BANK_W-1:0]          prg_bank,
    output mirror_t                        mir_mode
);

    localparam logic [OFS_W-1:0] OFS_PRG = OFS_W'(NUM_CHR);
    localparam logic [OFS_W-1:0] OFS_MIR = OFS_W'(NUM_CHR + 1);

    // One CHR bank register per 1 KiB PPU region.
    generate
        for (genvar g = 0; g < NUM_CHR; g++) begin : g_chr
            logic [CHR_BANK_W-1:0] bank_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bank_q <= '0;
                end else if (commit && ofs == OFS_W'(g)) begin
                    bank_q <= data[CHR_BANK_W-1:0];
                end
            end
            assign chr_flat[g*CHR_BANK_W +: CHR_BANK_W] = bank_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prg_bank <= '0;
        end else if (commit && ofs == OFS_PRG) begin
            prg_bank <= data[PRG_BANK_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mir_mode <= MIR_VERT;
        end else if (commit && ofs == OFS_MIR) begin
            mir_mode <= mirror_t'(data[1:0]);
        end
    end

endmodule

// File: rtl/bank_mapper_addr_gen.sv
module bank_mapper_addr_gen
    import bank_mapper_pkg::*;
#(
    parameter int NUM_CHR    = 8,
    parameter int CHR_BANK_W = 8,
    parameter int PRG_BANK_W = 4,
    parameter bit CHR_RAM    = 1'b0,
    parameter bit OUTER_MODE = 1'b0
) (
    input  logic                          cpu_a14,
    input  logic [3:0]                    ppu_a,
    input  logic [NUM_CHR*CHR_BANK_W-1:0] chr_flat,
    input  logic [PRG_BANK_W-1:0]         prg_bank,
    input  mirror_t                       mir_mode,
    output logic [PRG_BANK_W:0]           prg_hi,
    output logic [CHR_BANK_W-1:0]         chr_hi,
    output logic                          ciram_a10
);

    localparam int SEL_W = $clog2(NUM_CHR);

    logic [CHR_BANK_W-1:0] bank_arr [NUM_CHR];
    logic [SEL_W-1:0]      chr_sel;
    logic                  outer_bit;
    logic                  sink_unused;

    generate
        for (genvar g = 0; g < NUM_CHR; g++) begin : g_unpack
            assign bank_arr[g] = chr_flat[g*CHR_BANK_W +: CHR_BANK_W];
        end
    endgenerate

    assign chr_sel     = ppu_a[SEL_W-1:0];
    assign sink_unused = ^{chr_flat, ppu_a};

    // CHR path: banked ROM or straight pass-through for RAM/outer builds.
    generate
        if (CHR_RAM || OUTER_MODE) begin : g_chr_pass
            assign chr_hi = {{(CHR_BANK_W-SEL_W){1'b0}}, chr_sel};
        end else begin : g_chr_bank
            assign chr_hi = bank_arr[chr_sel];
        end
    endgenerate

    // Outer PRG bit: A12/A13 forced low, so only the first four banks count.
    generate
        if (OUTER_MODE) begin : g_outer
            logic [SEL_W-1:0] outer_idx;
            assign outer_idx = {{(SEL_W-2){1'b0}}, ppu_a[1:0]};
            assign outer_bit = bank_arr[outer_idx][0];
        end else begin : g_no_outer
            assign outer_bit = 1'b0;
        end
    endgenerate

    always_comb begin
        prg_hi[PRG_BANK_W] = outer_bit;
        if (cpu_a14) begin
            prg_hi[PRG_BANK_W-1:0] = '1;
        end else begin
            prg_hi[PRG_BANK_W-1:0] = prg_bank;
        end
    end

    always_comb begin
        ciram_a10 = 1'b0;
        unique case (mir_mode)
            MIR_VERT: ciram_a10 = ppu_a[0];
            MIR_HORZ: ciram_a10 = ppu_a[1];
            MIR_LOW:  ciram_a10 = 1'b0;
            MIR_HIGH: ciram_a10 = 1'b1;
            default:  ciram_a10 = 1'b0;
        endcase
    end

endmodule

// File: rtl/bank_mapper_top.sv
module bank_mapper_top
    import bank_mapper_pkg::*;
#(
    parameter bit WIN_FULL   = 1'b1,
    parameter bit CHR_RAM    = 1'b0,
    parameter bit OUTER_MODE = 1'b0,
    parameter int NUM_CHR    = 8,
    parameter int CHR_BANK_W = 8,
    parameter int PRG_BANK_W = 4,
    parameter int DATA_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           cpu_addr,
    input  logic [DATA_W-1:0]     cpu_data,
    input  logic                  cpu_wr,
    input  logic [3:0]            ppu_a13_10,
    output logic [PRG_BANK_W:0]   prg_addr_hi,
    output logic [CHR_BANK_W-1:0] chr_addr_hi,
    output logic                  ciram_a10
);

    localparam int OFS_W = 4;

    logic                          commit;
    logic [NUM_CHR*CHR_BANK_W-1:0] chr_flat;
    logic [PRG_BANK_W-1:0]         prg_bank;
    mirror_t                       mir_mode;
    logic                          addr_unused;

    assign addr_unused = ^cpu_addr[12:OFS_W];

    bank_mapper_wr_fsm #(
        .WIN_FULL (WIN_FULL)
    ) u_wr_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_hi (cpu_addr[15:13]),
        .cpu_wr  (cpu_wr),
        .commit  (commit)
    );

    bank_mapper_regs #(
        .NUM_CHR    (NUM_CHR),
        .CHR_BANK_W (CHR_BANK_W),
        .PRG_BANK_W (PRG_BANK_W),
        .DATA_W     (DATA_W),
        .OFS_W      (OFS_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .ofs      (cpu_addr[OFS_W-1:0]),
        .data     (cpu_data),
        .chr_flat (chr_flat),
        .prg_bank (prg_bank),
        .mir_mode (mir_mode)
    );

    bank_mapper_addr_gen #(
        .NUM_CHR    (NUM_CHR),
        .CHR_BANK_W (CHR_BANK_W),
        .PRG_BANK_W (PRG_BANK_W),
        .CHR_RAM    (CHR_RAM),
        .OUTER_MODE (OUTER_MODE)
    ) u_addr_gen (
        .cpu_a14   (cpu_addr[14]),
        .ppu_a     (ppu_a13_10),
        .chr_flat  (chr_flat),
        .prg_bank  (prg_bank),
        .mir_mode  (mir_mode),
        .prg_hi    (prg_addr_hi),
        .chr_hi    (chr_addr_hi),
        .ciram_a10 (ciram_a10)
    );

endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
    parameter bit WIN_FULL   = 1'b1,
    parameter bit CHR_RAM    = 1'b0,
    parameter bit OUTER_MODE = 1'b0,
    parameter int NUM_CHR    = 8,
    parameter int CHR_BANK_W = 8,
    parameter int PRG_BANK_W = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [15:0]                   cpu_addr,
    input logic                          cpu_wr,
    input logic [3:0]                    ppu_a,
    input logic [PRG_BANK_W:0]           prg_hi,
    input logic [CHR_BANK_W-1:0]         chr_hi,
    input logic                          ciram,
    input logic [NUM_CHR*CHR_BANK_W-1:0] chr_flat,
    input logic [PRG_BANK_W-1:0]         prg_bank,
    input logic [1:0]                    mir_mode
);

    logic in_window;
    assign in_window = WIN_FULL ? (cpu_addr >= 16'h6000) : (cpu_addr >= 16'h8000);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (chr_flat == '0 && prg_bank == '0 && mir_mode == 2'd0));

    // R3
    out_of_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !in_window) |=> ($stable(chr_flat) && $stable(prg_bank) && $stable(mir_mode)));

    // R4
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cpu_wr) && cpu_wr) |=>
            ($stable(chr_flat) && $stable(prg_bank) && $stable(mir_mode)));

    // R7
    fixed_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[14] |-> (prg_hi[PRG_BANK_W-1:0] == {PRG_BANK_W{1'b1}}));

    // R8
    tied_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mir_mode[1]) |-> (ciram == mir_mode[0]));

    generate
        if (CHR_RAM || OUTER_MODE) begin : g_pass_chk
            // R9
            chr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
                chr_hi == {{(CHR_BANK_W-3){1'b0}}, ppu_a[2:0]});
        end
        if (!OUTER_MODE) begin : g_no_outer_chk
            // R10
            outer_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !prg_hi[PRG_BANK_W]);
        end
    endgenerate

endmodule

bind bank_mapper_top bank_mapper_chk #(
    .WIN_FULL   (WIN_FULL),
    .CHR_RAM    (CHR_RAM),
    .OUTER_MODE (OUTER_MODE),
    .NUM_CHR    (NUM_CHR),
    .CHR_BANK_W (CHR_BANK_W),
    .PRG_BANK_W (PRG_BANK_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_wr   (cpu_wr),
    .ppu_a    (ppu_a13_10),
    .prg_hi   (prg_addr_hi),
    .chr_hi   (chr_addr_hi),
    .ciram    (ciram_a10),
    .chr_flat (chr_flat),
    .prg_bank (prg_bank),
    .mir_mode (mir_mode)
);

// File: tb/bank_mapper_top_bench.sv
`timescale 1ns/1ps
module bank_mapper_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_wr = 1'b0;
    logic [3:0]  ppu_a = 4'h0;

    logic [4:0] prg_o [3];
    logic [7:0] chr_o [3];
    logic       cir_o [3];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit live   = 1'b0;

    // Model state, one slot per build: 0 full window, 1 upper window + CHR RAM, 2 outer bank.
    int m_chr [3][8];
    int m_prg [3];
    int m_mir [3];
    bit prev_wr = 1'b0;

    always #5 clk = ~clk;

    bank_mapper_top #(.WIN_FULL(1'b1), .CHR_RAM(1'b0), .OUTER_MODE(1'b0)) u_bank_mapper_top (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
        .ppu_a13_10(ppu_a), .prg_addr_hi(prg_o[0]), .chr_addr_hi(chr_o[0]), .ciram_a10(cir_o[0]));

    bank_mapper_top #(.WIN_FULL(1'b0), .CHR_RAM(1'b1), .OUTER_MODE(1'b0)) u_bank_mapper_top_ram (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
        .ppu_a13_10(ppu_a), .prg_addr_hi(prg_o[1]), .chr_addr_hi(chr_o[1]), .ciram_a10(cir_o[1]));

    bank_mapper_top #(.WIN_FULL(1'b0), .CHR_RAM(1'b0), .OUTER_MODE(1'b1)) u_bank_mapper_top_outer (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
        .ppu_a13_10(ppu_a), .prg_addr_hi(prg_o[2]), .chr_addr_hi(chr_o[2]), .ciram_a10(cir_o[2]));

    function automatic bit accepts(int v, int a);
        if (v == 0) return a >= 'h6000;
        return a >= 'h8000;
    endfunction

    // Behavioural model: one commit per rising strobe.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < 3; v++) begin
                for (int i = 0; i < 8; i++) m_chr[v][i] = 0;
                m_prg[v] = 0;
                m_mir[v] = 0;
            end
            prev_wr = 1'b0;
        end else begin
            if (cpu_wr && !prev_wr) begin
                for (int v = 0; v < 3; v++) begin
                    if (accepts(v, int'(cpu_addr))) begin
                        int o;
                        o = int'(cpu_addr) % 16;
                        if (o < 8)       m_chr[v][o] = int'(cpu_data);
                        else if (o == 8) m_prg[v] = int'(cpu_data) % 16;
                        else if (o == 9) m_mir[v] = int'(cpu_data) % 4;
                    end
                end
            end
            prev_wr = cpu_wr;
        end
    end

    function automatic int exp_chr(int v);
        if (v == 0) return m_chr[0][int'(ppu_a) % 8];
        return int'(ppu_a) % 8;
    endfunction

    function automatic int exp_prg(int v);
        int inner;
        int outer;
        inner = cpu_addr[14] ? 15 : m_prg[v];
        outer = (v == 2) ? (m_chr[2][int'(ppu_a) % 4] % 2) : 0;
        return outer * 16 + inner;
    endfunction

    function automatic int exp_cir(int v);
        case (m_mir[v])
            0: return int'(ppu_a[0]);
            1: return int'(ppu_a[1]);
            2: return 0;
            default: return 1;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of every build against the model.
    always @(negedge clk) begin
        #2;
        if (live && rst_n && !done) begin
            for (int v = 0; v < 3; v++) begin
                chk(v == 0 ? "R5" : "R9", int'(chr_o[v]), exp_chr(v));
                chk(v == 2 ? "R10" : (cpu_addr[14] ? "R7" : "R6"), int'(prg_o[v]), exp_prg(v));
                chk("R8", int'(cir_o[v]), exp_cir(v));
            end
        end
    end

    task automatic cpu_write(int a, int d);
        @(negedge clk);
        cpu_addr = 16'(a);
        cpu_data = 8'(d);
        cpu_wr   = 1'b1;
        @(negedge clk);
        cpu_wr   = 1'b0;
        @(negedge clk);
    endtask

    task automatic look(int pa, int ca);
        @(negedge clk);
        ppu_a    = 4'(pa);
        cpu_addr = 16'(ca);
        #3;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        int snap_chr;
        int snap_prg;
        int snap_cir;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live  = 1'b1;

        // R1: reset state
        for (int p = 0; p < 8; p++) begin
            look(p, 16'h8000);
            chk("R1", int'(chr_o[0]), 0);
            chk("R1", int'(prg_o[0]), 0);
            chk("R1", int'(cir_o[0]), p % 2);
        end

        // R5: all eight CHR banks, ascending regions
        for (int i = 0; i < 8; i++) cpu_write('h8000 + i, 'h10 + i * 2);
        for (int p = 0; p < 16; p++) begin
            look(p, 16'h8000);
            chk("R5", int'(chr_o[0]), 'h10 + (p % 8) * 2);
        end

        // R6 / R7: upper nibble ignored, fixed last bank
        cpu_write('h8008, 'hF3);
        look(0, 16'h8000);
        chk("R6", int'(prg_o[0]), 3);
        look(0, 16'hC123);
        chk("R7", int'(prg_o[1]), 15);

        // R8: all four mirroring modes
        for (int m = 0; m < 4; m++) begin
            cpu_write('h8009, m);
            for (int p = 0; p < 4; p++) look(p, 16'h8000);
        end

        // R2: mirrored offsets
        cpu_write('hF3F4, 'h5A);
        look(4, 16'h8000);
        chk("R2", int'(chr_o[0]), 'h5A);
        cpu_write('hA019, 1);
        look(2, 16'h8000);
        chk("R2", int'(cir_o[0]), 1);

        // R3: low window reaches only the full-window build
        cpu_write('h7001, 'h01);
        look(1, 16'h8000);
        chk("R3", int'(chr_o[0]), 1);
        chk("R3", int'(prg_o[2]), 3);
        cpu_write('h2008, 'h09);
        look(0, 16'h8000);
        chk("R3", int'(prg_o[0]), 3);

        // R4: held strobe with changing data
        @(negedge clk);
        cpu_addr = 16'h8002; cpu_data = 8'h3C; cpu_wr = 1'b1;
        @(negedge clk); cpu_data = 8'h99;
        @(negedge clk); cpu_data = 8'h77;
        @(negedge clk); cpu_wr = 1'b0;
        look(2, 16'h8000);
        chk("R4", int'(chr_o[0]), 'h3C);

        // R11: unused offsets
        look(2, 16'h8000);
        snap_chr = int'(chr_o[0]); snap_prg = int'(prg_o[0]); snap_cir = int'(cir_o[0]);
        for (int o = 10; o < 16; o++) cpu_write('h8000 + o, 'hFF);
        look(2, 16'h8000);
        chk("R11", int'(chr_o[0]), snap_chr);
        chk("R11", int'(prg_o[0]), snap_prg);
        chk("R11", int'(cir_o[0]), snap_cir);

        // R10: outer bit from banks 0..3, A12/A13 ignored
        cpu_write('h8000, 'h01);
        cpu_write('h8001, 'h00);
        cpu_write('h8002, 'h03);
        cpu_write('h8003, 'h02);
        for (int p = 0; p < 16; p++) begin
            look(p, 16'h8000);
            chk("R10", int'(prg_o[2][4]), (p % 4 == 0 || p % 4 == 2) ? 1 : 0);
        end

        // R9: pass-through whatever the registers hold
        for (int p = 0; p < 16; p++) begin
            look(p, 16'h4000);
            chk("R9", int'(chr_o[1]), p % 8);
        end

        // Mixed random traffic, checked per cycle against the model
        for (int n = 0; n < 400; n++) begin
            cpu_write(int'($urandom_range(0, 'hFFFF)), int'($urandom_range(0, 255)));
            look(int'($urandom_range(0, 15)), int'($urandom_range(0, 'hFFFF)));
        end

        finish_run();
    end

endmodule